// File: doc/BRIEF.md
# Multicart CHR Outer Bank Composer

This block forms the upper picture-memory address lines, A20 down to A10, for a cartridge that holds many games in one large CHR store. It merges four sources into one address. The first is an outer base register written by the CPU. The second is a 1 KiB bank number delivered by an inner banking unit. The third is a small latch that any CPU write to the upper half of the CPU space loads. The fourth is picture-processor address bits A12..A10. The block also chooses whether CHR ROM or CHR RAM answers the access.

Three bits of a mode register pick the layout. In inner-banked layout, the inner bank number fills the low part of the address and the base register fills the rest. The window is 256 KiB or 128 KiB. In latch-banked layout, the picture-processor bits pass through and the CPU latch picks an 8 KiB page inside a 32 KiB or 16 KiB window. In fixed layout, the base register alone selects an 8 KiB page. Register writes take effect at the clock edge that samples the write. Changes on the inner bank and picture-processor inputs reach the outputs without a clock.

Top module: `chr_outer_composer`

## Requirements
- R1: After reset the mode, base and latch registers are zero. The output address is then {3'b000, inner_bank[7:0]} and chr_rom_cs=1, chr_ram_cs=0.
- R2: A cycle with cpu_wr_en=1 and base_wr_sel=1 loads cpu_data[7:0] into the base register. The output reflects the new value from that clock edge onward, and not before it.
- R3: When mode bit 6 is 0 and mode bit 4 is 0 (inner-banked, 256 KiB), chr_addr = {base[7:5], inner_bank[7:0]}.
- R4: When mode bit 6 is 0 and mode bit 4 is 1 (inner-banked, 128 KiB), chr_addr = {base[7:4], inner_bank[6:0]}.
- R5: When mode bit 6 is 1, bit 5 is 0 and bit 4 is 0 (latch-banked, 32 KiB), chr_addr = {base[7:2], latch[1:0], ppu_addr_hi[2:0]}.
- R6: When mode bit 6 is 1, bit 5 is 0 and bit 4 is 1 (latch-banked, 16 KiB), chr_addr = {base[7:1], latch[0], ppu_addr_hi[2:0]}.
- R7: When mode bits 6 and 5 are both 1 (fixed layout), chr_addr = {base[7:0], ppu_addr_hi[2:0]}, whatever bit 4 holds.
- R8: A cycle with cpu_wr_en=1 and cpu_addr >= 16'h8000 loads cpu_data[1:0] into the latch. A write below 16'h8000 leaves the latch unchanged.
- R9: Outside latch-banked layout, loading the latch does not change chr_addr.
- R10: chr_ram_cs=1 exactly when mode bit 6 is 0 and bit 5 is 1. chr_rom_cs is its complement, so exactly one select is high.
- R11: A cycle with mode_wr_sel=1 loads mode bits 6..4 from cpu_data[6:4] only when cpu_wr_en=1. A strobe without cpu_wr_en has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU write cycle qualifier |
| cpu_addr | input | 16 | CPU address; the upper half loads the latch |
| cpu_data | input | 8 | CPU write data |
| mode_wr_sel | input | 1 | Strobe that selects the mode register for this write |
| base_wr_sel | input | 1 | Strobe that selects the CHR base register for this write |
| ppu_addr_hi | input | 3 | Picture-processor address A12..A10 |
| inner_bank | input | 8 | 1 KiB bank number from the inner banking unit |
| chr_addr | output | 11 | CHR address A20..A10 |
| chr_rom_cs | output | 1 | CHR ROM select |
| chr_ram_cs | output | 1 | CHR RAM select |

## Verification
The block has two kinds of result, and each has its own timing. A register write (mode, base or latch) shows on chr_addr and on the selects after exactly one rising edge. So each write is driven on a falling edge, held across the next rising edge and removed at the following falling edge, and the check samples at that falling edge. The inner bank and picture-processor inputs reach the outputs within the same cycle. Those inputs are changed mid-cycle and sampled one nanosecond later, well before the next rising edge. The base-write test also samples once before the capturing edge, which shows that the old value still holds until the edge.

// File: rtl/chr_comp_pkg.sv
package chr_comp_pkg;

  // Decoded layout controls, taken from mode bits 6..4 at write time.
  typedef struct packed {
    logic ppu_low;    // bit 6: A12..A10 from picture processor
    logic alt_sel;    // bit 5: RAM select (inner) or latch disable
    logic small_win;  // bit 4: halve the outer window
  } chr_mode_t;

  typedef enum logic [1:0] {
    LAY_INNER = 2'd0,
    LAY_LATCH = 2'd1,
    LAY_FIXED = 2'd2
  } chr_layout_e;

  localparam logic [15:0] LATCH_SPACE_LO = 16'h8000;

  function automatic chr_mode_t mode_from_byte(input logic [7:0] b);
    chr_mode_t m;
    m.ppu_low   = b[6];
    m.alt_sel   = b[5];
    m.small_win = b[4];
    return m;
  endfunction

  function automatic chr_layout_e layout_of(input chr_mode_t m);
    if (!m.ppu_low)     return LAY_INNER;
    else if (m.alt_sel) return LAY_FIXED;
    else                return LAY_LATCH;
  endfunction

  function automatic logic ram_selected(input chr_mode_t m);
    return (layout_of(m) == LAY_INNER) && m.alt_sel;
  endfunction

endpackage

// File: rtl/chr_cfg_regs.sv
module chr_cfg_regs
  import chr_comp_pkg::*;
#(
  parameter int BASE_W  = 8,
  parameter int LATCH_W = 2,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_we,
  input  logic               base_we,
  input  logic               latch_we,
  input  logic [DATA_W-1:0]  wdata,
  output chr_mode_t          mode_q,
  output logic [BASE_W-1:0]  base_q,
  output logic [LATCH_W-1:0] latch_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      base_q  <= '0;
      latch_q <= '0;
    end else begin
      if (mode_we)  mode_q  <= mode_from_byte(wdata[7:0]);
      if (base_we)  base_q  <= wdata[BASE_W-1:0];
      if (latch_we) latch_q <= wdata[LATCH_W-1:0];
    end
  end

endmodule

// File: rtl/chr_addr_mux.sv
module chr_addr_mux
  import chr_comp_pkg::*;
#(
  parameter int BASE_W  = 8,
  parameter int INNER_W = 8,
  parameter int LATCH_W = 2,
  parameter int PPU_W   = 3,
  localparam int ADDR_W = BASE_W + PPU_W
) (
  input  chr_mode_t          mode,
  input  logic [BASE_W-1:0]  base,
  input  logic [LATCH_W-1:0] latch,
  input  logic [INNER_W-1:0] inner,
  input  logic [PPU_W-1:0]   ppu,
  output logic [ADDR_W-1:0]  addr,
  output logic               rom_cs,
  output logic               ram_cs
);

  typedef logic [ADDR_W-1:0] addr_t;

  // Ones in the n lowest positions.
  function automatic addr_t low_mask(input int n);
    addr_t m;
    for (int i = 0; i < ADDR_W; i++) m[i] = (i < n);
    return m;
  endfunction

  // Replace the n lowest bits of the base-derived address by 'low'.
  function automatic addr_t splice(input addr_t hi, input addr_t low, input int n);
    addr_t m;
    m = low_mask(n);
    return (hi & ~m) | (low & m);
  endfunction

  addr_t       base_full;
  addr_t       inner_ext;
  addr_t       latch_ext;
  int          inner_keep;
  int          latch_keep;
  chr_layout_e lay;

  assign base_full  = {base, {PPU_W{1'b0}}};
  assign inner_ext  = addr_t'(inner);
  assign latch_ext  = addr_t'({latch, ppu});
  assign inner_keep = mode.small_win ? INNER_W - 1 : INNER_W;
  assign latch_keep = (mode.small_win ? LATCH_W - 1 : LATCH_W) + PPU_W;
  assign lay        = layout_of(mode);

  always_comb begin
    unique case (lay)
      LAY_INNER: addr = splice(base_full, inner_ext, inner_keep);
      LAY_LATCH: addr = splice(base_full, latch_ext, latch_keep);
      default:   addr = splice(base_full, addr_t'(ppu), PPU_W);
    endcase
  end

  assign ram_cs = ram_selected(mode);
  assign rom_cs = ~ram_cs;

endmodule

// File: rtl/chr_outer_composer.sv
module chr_outer_composer
  import chr_comp_pkg::*;
#(
  parameter int BASE_W  = 8,
  parameter int INNER_W = 8,
  parameter int LATCH_W = 2,
  parameter int PPU_W   = 3,
  localparam int ADDR_W = BASE_W + PPU_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_wr_en,
  input  logic [15:0]        cpu_addr,
  input  logic [7:0]         cpu_data,
  input  logic               mode_wr_sel,
  input  logic               base_wr_sel,
  input  logic [PPU_W-1:0]   ppu_addr_hi,
  input  logic [INNER_W-1:0] inner_bank,
  output logic [ADDR_W-1:0]  chr_addr,
  output logic               chr_rom_cs,
  output logic               chr_ram_cs
);

  // Named write events, visible to the checker.
  logic mode_we;
  logic base_we;
  logic latch_we;

  assign mode_we  = cpu_wr_en && mode_wr_sel;
  assign base_we  = cpu_wr_en && base_wr_sel;
  assign latch_we = cpu_wr_en && (cpu_addr >= LATCH_SPACE_LO);

  chr_mode_t          mode_q;
  logic [BASE_W-1:0]  base_q;
  logic [LATCH_W-1:0] latch_q;

  chr_cfg_regs #(
    .BASE_W (BASE_W),
    .LATCH_W(LATCH_W),
    .DATA_W (8)
  ) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_we (mode_we),
    .base_we (base_we),
    .latch_we(latch_we),
    .wdata   (cpu_data),
    .mode_q  (mode_q),
    .base_q  (base_q),
    .latch_q (latch_q)
  );

  chr_addr_mux #(
    .BASE_W (BASE_W),
    .INNER_W(INNER_W),
    .LATCH_W(LATCH_W),
    .PPU_W  (PPU_W)
  ) mux_i (
    .mode  (mode_q),
    .base  (base_q),
    .latch (latch_q),
    .inner (inner_bank),
    .ppu   (ppu_addr_hi),
    .addr  (chr_addr),
    .rom_cs(chr_rom_cs),
    .ram_cs(chr_ram_cs)
  );

endmodule

// File: rtl/chr_outer_composer_chk.sv
module chr_outer_composer_chk #(
  parameter int BASE_W  = 8,
  parameter int INNER_W = 8,
  parameter int LATCH_W = 2,
  parameter int PPU_W   = 3,
  localparam int ADDR_W = BASE_W + PPU_W,
  localparam int TOP_N  = ADDR_W - INNER_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_wr_en,
  input logic               mode_wr_sel,
  input logic               latch_we,
  input logic [7:0]         cpu_data,
  input logic [PPU_W-1:0]   ppu_addr_hi,
  input logic [INNER_W-1:0] inner_bank,
  input logic [ADDR_W-1:0]  chr_addr,
  input logic               chr_rom_cs,
  input logic               chr_ram_cs,
  input logic [2:0]         mode_bits,
  input logic [BASE_W-1:0]  base_q,
  input logic [LATCH_W-1:0] latch_q
);

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({chr_rom_cs, chr_ram_cs}) == 1); // R10

  AST_RAM_ONLY_INNER: assert property (@(posedge clk) disable iff (!rst_n)
    chr_ram_cs |-> !mode_bits[2]); // R10

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    latch_we |=> latch_q == $past(cpu_data[LATCH_W-1:0])); // R8

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_we |=> $stable(latch_q)); // R8

  AST_MODE_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_sel && !cpu_wr_en) |=> $stable(mode_bits)); // R11

  AST_PPU_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bits[2] |-> chr_addr[PPU_W-1:0] == ppu_addr_hi); // R7

  AST_INNER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_bits[2] |-> chr_addr[INNER_W-2:0] == inner_bank[INNER_W-2:0]); // R4

  AST_BASE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    chr_addr[ADDR_W-1 -: TOP_N] == base_q[BASE_W-1 -: TOP_N]); // R3

endmodule

bind chr_outer_composer chr_outer_composer_chk #(
  .BASE_W (BASE_W),
  .INNER_W(INNER_W),
  .LATCH_W(LATCH_W),
  .PPU_W  (PPU_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_wr_en  (cpu_wr_en),
  .mode_wr_sel(mode_wr_sel),
  .latch_we   (latch_we),
  .cpu_data   (cpu_data),
  .ppu_addr_hi(ppu_addr_hi),
  .inner_bank (inner_bank),
  .chr_addr   (chr_addr),
  .chr_rom_cs (chr_rom_cs),
  .chr_ram_cs (chr_ram_cs),
  .mode_bits  (mode_q),
  .base_q     (base_q),
  .latch_q    (latch_q)
);

// File: tb/chr_outer_composer_tb.sv
module chr_outer_composer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr_en = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        mode_wr_sel = 1'b0;
  logic        base_wr_sel = 1'b0;
  logic [2:0]  ppu_addr_hi = 3'd0;
  logic [7:0]  inner_bank = 8'h00;
  logic [10:0] chr_addr;
  logic        chr_rom_cs;
  logic        chr_ram_cs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  chr_outer_composer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_wr_en  (cpu_wr_en),
    .cpu_addr   (cpu_addr),
    .cpu_data   (cpu_data),
    .mode_wr_sel(mode_wr_sel),
    .base_wr_sel(base_wr_sel),
    .ppu_addr_hi(ppu_addr_hi),
    .inner_bank (inner_bank),
    .chr_addr   (chr_addr),
    .chr_rom_cs (chr_rom_cs),
    .chr_ram_cs (chr_ram_cs)
  );

  typedef struct packed {
    logic [7:0]  mode;
    logic [7:0]  base;
    logic [1:0]  lat;
    logic [7:0]  inner;
    logic [2:0]  ppu;
    logic [10:0] addr;
    logic        rom;
    logic        ram;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'hA5, 2'd3, 8'h3C, 3'd5, 11'h53C, 1'b1, 1'b0, 4'd3},  // R3
    '{8'h10, 8'hA5, 2'd3, 8'hFF, 3'd5, 11'h57F, 1'b1, 1'b0, 4'd4},  // R4
    '{8'h20, 8'h00, 2'd0, 8'h81, 3'd2, 11'h081, 1'b0, 1'b1, 4'd10}, // R10
    '{8'h40, 8'hA5, 2'd2, 8'h00, 3'd5, 11'h535, 1'b1, 1'b0, 4'd5},  // R5
    '{8'h50, 8'hA5, 2'd2, 8'h00, 3'd6, 11'h526, 1'b1, 1'b0, 4'd6},  // R6
    '{8'h50, 8'h5A, 2'd3, 8'hFF, 3'd1, 11'h2D9, 1'b1, 1'b0, 4'd6},  // R6
    '{8'h60, 8'h5A, 2'd3, 8'h00, 3'd7, 11'h2D7, 1'b1, 1'b0, 4'd7},  // R7
    '{8'h70, 8'hFF, 2'd1, 8'h33, 3'd0, 11'h7F8, 1'b1, 1'b0, 4'd7},  // R7
    '{8'h30, 8'h0F, 2'd0, 8'h80, 3'd4, 11'h000, 1'b0, 1'b1, 4'd4}   // R4
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d,
                           input logic we, input logic msel, input logic bsel);
    @(negedge clk);
    cpu_wr_en = we; cpu_addr = a; cpu_data = d;
    mode_wr_sel = msel; base_wr_sel = bsel;
    @(negedge clk);
    cpu_wr_en = 1'b0; cpu_addr = 16'h0000;
    mode_wr_sel = 1'b0; base_wr_sel = 1'b0;
  endtask

  task automatic set_mode(input logic [7:0] m);
    cpu_write(16'h5000, m, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic set_base(input logic [7:0] b);
    cpu_write(16'h5002, b, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic load_latch(input logic [15:0] a, input logic [7:0] d);
    cpu_write(a, d, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic put_inputs(input logic [7:0] ib, input logic [2:0] pp);
    inner_bank = ib; ppu_addr_hi = pp;
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, inner-banked 256 KiB, ROM selected
    put_inputs(8'h12, 3'd3);
    chk("R1 addr", 32'(chr_addr), 32'h012);
    chk("R1 rom", 32'(chr_rom_cs), 32'd1);
    chk("R1 ram", 32'(chr_ram_cs), 32'd0);

    // Table of layouts
    for (int i = 0; i < NV; i++) begin
      set_mode(VECS[i].mode);
      set_base(VECS[i].base);
      load_latch(16'h8000, {6'd0, VECS[i].lat});
      put_inputs(VECS[i].inner, VECS[i].ppu);
      chk($sformatf("R%0d vec%0d addr", VECS[i].req, i), 32'(chr_addr), 32'(VECS[i].addr));
      chk($sformatf("R10 vec%0d rom", i), 32'(chr_rom_cs), 32'(VECS[i].rom));
      chk($sformatf("R10 vec%0d ram", i), 32'(chr_ram_cs), 32'(VECS[i].ram));
    end

    // R2: base write is invisible until the capturing edge
    set_mode(8'h60);
    set_base(8'h00);
    put_inputs(8'h00, 3'd0);
    @(negedge clk);
    cpu_wr_en = 1'b1; base_wr_sel = 1'b1; cpu_data = 8'h81; cpu_addr = 16'h5002;
    #1;
    chk("R2 before edge", 32'(chr_addr), 32'h000);
    @(negedge clk);
    cpu_wr_en = 1'b0; base_wr_sel = 1'b0; cpu_addr = 16'h0000;
    chk("R2 after edge", 32'(chr_addr), 32'h408);

    // R8: latch loads only from the upper CPU half
    set_mode(8'h40);
    set_base(8'h00);
    load_latch(16'hC123, 8'h01);
    put_inputs(8'h00, 3'd0);
    chk("R8 load", 32'(chr_addr), 32'h008);
    load_latch(16'h7FFF, 8'h03);
    chk("R8 low write ignored", 32'(chr_addr), 32'h008);
    load_latch(16'hFFFF, 8'h02);
    chk("R8 top address", 32'(chr_addr), 32'h010);

    // R9: latch has no effect in inner-banked and fixed layouts
    set_mode(8'h00);
    put_inputs(8'h55, 3'd2);
    chk("R9 inner before", 32'(chr_addr), 32'h055);
    load_latch(16'h8000, 8'h03);
    chk("R9 inner after", 32'(chr_addr), 32'h055);
    set_mode(8'h60);
    set_base(8'h3C);
    load_latch(16'h9000, 8'h00);
    chk("R9 fixed after", 32'(chr_addr), 32'h1E2);

    // R11: mode strobe without write enable is ignored
    set_mode(8'h00);
    set_base(8'h00);
    put_inputs(8'hC7, 3'd1);
    cpu_write(16'h5000, 8'h60, 1'b0, 1'b1, 1'b0);
    chk("R11 addr", 32'(chr_addr), 32'h0C7);
    cpu_write(16'h5000, 8'h20, 1'b0, 1'b1, 1'b0);
    chk("R11 ram", 32'(chr_ram_cs), 32'd0);

    // R1: reset clears registers again
    set_mode(8'h20);
    set_base(8'hFF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    put_inputs(8'h12, 3'd3);
    chk("R1 re-reset addr", 32'(chr_addr), 32'h012);
    chk("R1 re-reset ram", 32'(chr_ram_cs), 32'd0);

    done = 1'b1;
    finish_run();
  end

endmodule